// File: doc/BRIEF.md
# Bit-Banged I2C Bus Decoder

This block follows the SDA and SCL levels of a two-wire bus that software drives through a pair of general-purpose pins. It samples both lines on the system clock and turns them into transaction events for a target model that sits beside it. The events are: the start of a transfer, carrying the 7-bit address and the read/write flag; a strobe for each byte the master writes; a request each time a byte is taken for a read; a pulse when the master refuses a byte; and the end of the transfer.

During a read the block also produces the SDA level that the target returns to the master. It shifts out, most significant bit first, the byte presented on `rd_byte_i`. That byte is treated as the head of a queue: it is latched on the SCL falling edge that begins a byte, and `rd_req_o` then pulses to tell the target to advance. All detection runs on registered copies of the previous samples. The block has no analog drive, no clock stretching and no arbitration.

Top module: `i2c_bitbang_decoder`

## Requirements
- R1: After reset the block is idle with no address captured: every event output is 0, `sda_o` is 0, `addr_o` is 0 and `rnw_o` is 0.
- R2: The idle state is left only when SDA goes from 1 to 0 while SCL is 1. From the state that follows, only an SCL fall with SDA at 0 leads into the first data bit. Any other change of either line returns the block to idle and produces no event.
- R3: Each written byte is assembled from the SDA level at eight successive SCL falling edges, most significant bit first. A ninth SCL fall closes the acknowledge slot.
- R4: At the SCL fall that closes the first acknowledge slot after a start, `start_o` pulses one clock later. With it, `addr_o` takes byte bits [7:1] and `rnw_o` takes byte bit 0. Both hold until the next captured address.
- R5: In a write transfer (`rnw_o` = 0), every later byte produces a `wr_strobe_o` pulse one clock after its acknowledge slot closes, with the byte on `wr_data_o`.
- R6: In a read transfer, the SCL fall that closes the address acknowledge slot latches `rd_byte_i` and pulses `rd_req_o`. `sda_o` then presents the latched byte MSB first, moving to the next bit at each SCL fall.
- R7: After eight read bits the master acknowledge slot follows. At its SCL fall, SDA at 0 latches `rd_byte_i` and pulses `rd_req_o`, while SDA at 1 pulses `nack_o` instead. In both cases reading continues.
- R8: `sda_o` is 0 in every state except the eight read-bit states, which includes both acknowledge slots.
- R9: In any bit or acknowledge state, SDA rising while SCL is 1 returns the block to idle. `stop_o` pulses only if an address byte was already captured.
- R10: Every event output is a single-cycle pulse, and at most one of `start_o`, `wr_strobe_o`, `nack_o` and `stop_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Sampled SDA level driven by the master |
| scl_i | input | 1 | Sampled SCL level |
| rd_byte_i | input | 8 | Next byte the target returns in a read |
| start_o | output | 1 | Pulse: address byte captured |
| addr_o | output | 7 | Captured 7-bit target address |
| rnw_o | output | 1 | Captured read flag (1 = read) |
| wr_strobe_o | output | 1 | Pulse: written byte on `wr_data_o` |
| wr_data_o | output | 8 | Last written data byte |
| rd_req_o | output | 1 | Pulse: `rd_byte_i` consumed, present the next byte |
| nack_o | output | 1 | Pulse: master refused the last read byte |
| stop_o | output | 1 | Pulse: transfer ended after an address |
| sda_o | output | 1 | SDA level returned to the master |

## Verification
A bit counter that is off by one moves every captured byte by one position. The first symptom is a wrong `addr_o` or `rnw_o` on the next `start_o`, seen within one byte time. A wrong state on the read side shows up as a mismatched bit or a non-zero level on `sda_o` during an acknowledge slot, within the same SCL period. A lost record of the captured address shows up at the following stop, as a missing or spurious `stop_o` pulse one clock after SDA rises.

// File: rtl/i2c_dec_pkg.sv
package i2c_dec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_WBIT,
    ST_SACK,
    ST_RBIT,
    ST_MACK
  } dec_state_e;

  typedef enum logic [1:0] {
    SH_HOLD,
    SH_IN,
    SH_LEFT,
    SH_LOAD
  } shift_op_e;

endpackage

// File: rtl/i2c_dec_sampler.sv
module i2c_dec_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic scl_fall_o,
  output logic start_cond_o,
  output logic stop_cond_o,
  output logic bus_change_o
);

  logic sda_q, scl_q;

  // previous samples updated every cycle, independent of state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  assign scl_fall_o   = scl_q & ~scl_i;
  assign start_cond_o = sda_q & ~sda_i & scl_i;
  assign stop_cond_o  = ~sda_q & sda_i & scl_i;
  assign bus_change_o = (sda_q ^ sda_i) | (scl_q ^ scl_i);

endmodule

// File: rtl/i2c_dec_shifter.sv
module i2c_dec_shifter
  import i2c_dec_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  shift_op_e         op_i,
  input  logic              ser_i,
  input  logic [BYTE_W-1:0] load_i,
  output logic [BYTE_W-1:0] q_o
);

  logic [BYTE_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      unique case (op_i)
        SH_IN:   q_q <= {q_q[BYTE_W-2:0], ser_i};
        SH_LEFT: q_q <= {q_q[BYTE_W-2:0], 1'b0};
        SH_LOAD: q_q <= load_i;
        default: q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/i2c_dec_fsm.sv
module i2c_dec_fsm
  import i2c_dec_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_fall_i,
  input  logic              start_cond_i,
  input  logic              stop_cond_i,
  input  logic              bus_change_i,
  input  logic [BYTE_W-1:0] shreg_i,
  output shift_op_e         op_o,
  output dec_state_e        state_o,
  output logic              start_o,
  output logic [BYTE_W-2:0] addr_o,
  output logic              rnw_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              rdreq_o,
  output logic              nack_o,
  output logic              stop_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  dec_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              addr_vld_q, addr_vld_d;
  logic [BYTE_W-2:0] addr_q;
  logic              rnw_q;
  logic              cap_addr;
  logic              is_rd;
  logic              do_stop;
  logic              ev_start, ev_wr, ev_rdreq, ev_nack, ev_stop;
  shift_op_e         op;

  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    addr_vld_d = addr_vld_q;
    op         = SH_HOLD;
    cap_addr   = 1'b0;
    is_rd      = 1'b0;
    do_stop    = 1'b0;
    ev_start   = 1'b0;
    ev_wr      = 1'b0;
    ev_rdreq   = 1'b0;
    ev_nack    = 1'b0;
    ev_stop    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_cond_i) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (scl_fall_i && !sda_i) begin
          state_d = ST_WBIT;
          bit_d   = '0;
        end else if (bus_change_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_WBIT: begin
        if (scl_fall_i) begin
          op    = SH_IN;
          bit_d = bit_q + CNT_W'(1);
          if (bit_q == LAST_BIT) state_d = ST_SACK;
        end else if (stop_cond_i) begin
          do_stop = 1'b1;
        end
      end
      ST_SACK: begin
        if (scl_fall_i) begin
          if (!addr_vld_q) begin
            cap_addr   = 1'b1;
            addr_vld_d = 1'b1;
            ev_start   = 1'b1;
            is_rd      = shreg_i[0];
          end else begin
            ev_wr = 1'b1;
            is_rd = rnw_q;
          end
          bit_d = '0;
          if (is_rd) begin
            op       = SH_LOAD;
            ev_rdreq = 1'b1;
            state_d  = ST_RBIT;
          end else begin
            state_d = ST_WBIT;
          end
        end else if (stop_cond_i) begin
          do_stop = 1'b1;
        end
      end
      ST_RBIT: begin
        if (scl_fall_i) begin
          op    = SH_LEFT;
          bit_d = bit_q + CNT_W'(1);
          if (bit_q == LAST_BIT) state_d = ST_MACK;
        end else if (stop_cond_i) begin
          do_stop = 1'b1;
        end
      end
      ST_MACK: begin
        if (scl_fall_i) begin
          if (!sda_i) begin
            op       = SH_LOAD;
            ev_rdreq = 1'b1;
          end else begin
            ev_nack = 1'b1;
          end
          bit_d   = '0;
          state_d = ST_RBIT;
        end else if (stop_cond_i) begin
          do_stop = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (do_stop) begin
      state_d    = ST_IDLE;
      ev_stop    = addr_vld_q;
      addr_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      addr_vld_q <= 1'b0;
      addr_q     <= '0;
      rnw_q      <= 1'b0;
      wdata_o    <= '0;
      start_o    <= 1'b0;
      wr_o       <= 1'b0;
      rdreq_o    <= 1'b0;
      nack_o     <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      state_q    <= state_d;
      bit_q      <= bit_d;
      addr_vld_q <= addr_vld_d;
      if (cap_addr) begin
        addr_q <= shreg_i[BYTE_W-1:1];
        rnw_q  <= shreg_i[0];
      end
      if (ev_wr) wdata_o <= shreg_i;
      start_o <= ev_start;
      wr_o    <= ev_wr;
      rdreq_o <= ev_rdreq;
      nack_o  <= ev_nack;
      stop_o  <= ev_stop;
    end
  end

  assign op_o    = op;
  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign rnw_o   = rnw_q;

endmodule

// File: rtl/i2c_bitbang_decoder.sv
module i2c_bitbang_decoder
  import i2c_dec_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              start_o,
  output logic [BYTE_W-2:0] addr_o,
  output logic              rnw_o,
  output logic              wr_strobe_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic              nack_o,
  output logic              stop_o,
  output logic              sda_o
);

  logic              scl_fall_w, start_cond_w, stop_cond_w, bus_change_w;
  logic [BYTE_W-1:0] shreg_w;
  shift_op_e         op_w;
  dec_state_e        state_w;

  i2c_dec_sampler u_sampler (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_i        (sda_i),
    .scl_i        (scl_i),
    .scl_fall_o   (scl_fall_w),
    .start_cond_o (start_cond_w),
    .stop_cond_o  (stop_cond_w),
    .bus_change_o (bus_change_w)
  );

  i2c_dec_shifter #(.BYTE_W(BYTE_W)) u_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op_w),
    .ser_i  (sda_i),
    .load_i (rd_byte_i),
    .q_o    (shreg_w)
  );

  i2c_dec_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_i        (sda_i),
    .scl_fall_i   (scl_fall_w),
    .start_cond_i (start_cond_w),
    .stop_cond_i  (stop_cond_w),
    .bus_change_i (bus_change_w),
    .shreg_i      (shreg_w),
    .op_o         (op_w),
    .state_o      (state_w),
    .start_o      (start_o),
    .addr_o       (addr_o),
    .rnw_o        (rnw_o),
    .wr_o         (wr_strobe_o),
    .wdata_o      (wr_data_o),
    .rdreq_o      (rd_req_o),
    .nack_o       (nack_o),
    .stop_o       (stop_o)
  );

  // target drives data only while read bits are on the bus
  assign sda_o = (state_w == ST_RBIT) && shreg_w[BYTE_W-1];

endmodule

// File: rtl/i2c_dec_checker.sv
module i2c_dec_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_i,
  input logic              scl_i,
  input logic              start_o,
  input logic [BYTE_W-2:0] addr_o,
  input logic              rnw_o,
  input logic              wr_strobe_o,
  input logic              rd_req_o,
  input logic              nack_o,
  input logic              stop_o,
  input logic              sda_o
);

  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, wr_strobe_o, nack_o, stop_o})); // R10

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R10

  AST_RDREQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o); // R10

  AST_START_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(scl_i, 2) && !$past(scl_i))); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> $stable(addr_o)); // R4

  AST_WR_IS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> !rnw_o); // R5

  AST_NACK_SDA_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> $past(sda_i)); // R7

  AST_SDA_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_o |-> rnw_o); // R8

  AST_STOP_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> ($past(sda_i) && $past(scl_i) && !$past(sda_i, 2))); // R9

endmodule

bind i2c_bitbang_decoder i2c_dec_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sda_i       (sda_i),
  .scl_i       (scl_i),
  .start_o     (start_o),
  .addr_o      (addr_o),
  .rnw_o       (rnw_o),
  .wr_strobe_o (wr_strobe_o),
  .rd_req_o    (rd_req_o),
  .nack_o      (nack_o),
  .stop_o      (stop_o),
  .sda_o       (sda_o)
);

// File: tb/i2c_bitbang_decoder_tb_top.sv
module i2c_bitbang_decoder_tb_top;

  localparam int HOLD = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sda = 1'b1;
  logic       scl = 1'b1;
  logic [7:0] rd_byte;
  logic       start_w, rnw_w, wr_w, rdreq_w, nack_w, stop_w, sda_w;
  logic [6:0] addr_w;
  logic [7:0] wdata_w;

  int checks = 0;
  int errors = 0;
  int n_start, n_wr, n_rdreq, n_nack, n_stop, n_dbl;
  int rd_idx = 0;
  logic [6:0] got_addr;
  logic       got_rnw;
  logic [7:0] wr_got [16];
  logic [4:0] prev_evt = '0;
  logic [7:0] wbuf [4];

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int k);
    return 8'h5A ^ 8'(k * 29);
  endfunction

  assign rd_byte = pat(rd_idx);

  i2c_bitbang_decoder dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sda_i       (sda),
    .scl_i       (scl),
    .rd_byte_i   (rd_byte),
    .start_o     (start_w),
    .addr_o      (addr_w),
    .rnw_o       (rnw_w),
    .wr_strobe_o (wr_w),
    .wr_data_o   (wdata_w),
    .rd_req_o    (rdreq_w),
    .nack_o      (nack_w),
    .stop_o      (stop_w),
    .sda_o       (sda_w)
  );

  // event monitor, samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] evt;
      evt = {start_w, wr_w, rdreq_w, nack_w, stop_w};
      if ((evt & prev_evt) != 0) n_dbl++;
      prev_evt = evt;
      if (start_w) begin n_start++; got_addr = addr_w; got_rnw = rnw_w; end
      if (wr_w) begin
        if (n_wr < 16) wr_got[n_wr] = wdata_w;
        n_wr++;
      end
      if (rdreq_w) begin n_rdreq++; rd_idx++; end
      if (nack_w) n_nack++;
      if (stop_w) n_stop++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    n_start = 0; n_wr = 0; n_rdreq = 0; n_nack = 0; n_stop = 0; n_dbl = 0;
  endtask

  task automatic setb(input logic d, input logic c);
    @(posedge clk);
    #2;
    sda = d;
    scl = c;
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic bus_start();
    setb(1, 1); setb(0, 1); setb(0, 0);
  endtask

  task automatic bus_stop();
    setb(0, 0); setb(0, 1); setb(1, 1);
  endtask

  task automatic wbit(input logic b);
    setb(b, 0); setb(b, 1); setb(b, 0);
  endtask

  task automatic wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
  endtask

  // acknowledge slot of either side; sda_o must be low throughout (R8)
  task automatic ack_slot(input logic b);
    setb(b, 0);
    setb(b, 1);
    @(negedge clk);
    chk(sda_w == 1'b0, "R8", "sda_o in ack slot", sda_w, 0);
    setb(b, 0);
  endtask

  task automatic rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      setb(1, 0);
      setb(1, 1);
      @(negedge clk);
      v[i] = sda_w;
      setb(1, 0);
    end
  endtask

  task automatic xfer(input logic [6:0] a, input logic rw, input int n);
    logic [7:0] rb;
    int base;
    clr();
    base = rd_idx;
    bus_start();
    wbyte({a, rw});
    ack_slot(1'b0);
    for (int i = 0; i < n; i++) begin
      if (!rw) begin
        wbyte(wbuf[i]);
        ack_slot(1'b0);
      end else begin
        rbyte(rb);
        chk(rb == pat(base + i), "R6", "read byte on sda_o", rb, pat(base + i));
        ack_slot(i == n - 1); // R7: ack all but last
      end
    end
    bus_stop();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(n_start == 1, "R4", "start pulses", n_start, 1);
    chk(got_addr == a, "R4", "addr_o", got_addr, a);
    chk(got_rnw == rw, "R4", "rnw_o", got_rnw, rw);
    chk(n_wr == (rw ? 0 : n), "R5", "write strobes", n_wr, rw ? 0 : n);
    if (!rw)
      for (int i = 0; i < n; i++)
        chk(wr_got[i] == wbuf[i], "R3", "write byte MSB first", wr_got[i], wbuf[i]);
    chk(n_rdreq == (rw ? n : 0), "R7", "read requests", n_rdreq, rw ? n : 0);
    chk(n_nack == int'(rw), "R7", "nack pulses", n_nack, rw);
    chk(n_stop == 1, "R9", "stop after address", n_stop, 1);
    chk(n_dbl == 0, "R10", "multi-cycle event", n_dbl, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clr();
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk({start_w, wr_w, rdreq_w, nack_w, stop_w} == 5'd0, "R1", "events after reset",
        {start_w, wr_w, rdreq_w, nack_w, stop_w}, 0);
    chk(sda_w == 1'b0 && addr_w == 7'd0 && rnw_w == 1'b0, "R1", "outputs after reset",
        {sda_w, addr_w, rnw_w}, 0);

    // R2: idle ignores SCL toggling and a lone byte without start
    clr();
    wbyte(8'hA4);
    ack_slot(1'b0);
    setb(1, 1);
    repeat (2) @(posedge clk);
    chk(n_start + n_wr + n_stop == 0, "R2", "events without start", n_start + n_wr + n_stop, 0);

    // R2: start then SDA change instead of SCL fall aborts
    clr();
    setb(1, 1); setb(0, 1); setb(1, 1);
    wbyte(8'h6C);
    ack_slot(1'b0);
    setb(1, 1);
    repeat (2) @(posedge clk);
    chk(n_start == 0 && n_stop == 0, "R2", "aborted start events", n_start + n_stop, 0);

    // R9: stop before address completes gives no stop pulse
    clr();
    bus_start();
    wbit(1); wbit(0); wbit(1);
    bus_stop();
    repeat (2) @(posedge clk);
    chk(n_stop == 0, "R9", "stop without address", n_stop, 0);
    chk(n_start == 0, "R9", "start without address", n_start, 0);

    // directed corners
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00; wbuf[2] = 8'h81;
    xfer(7'h00, 1'b0, 3);
    xfer(7'h7F, 1'b1, 1);
    xfer(7'h1A, 1'b1, 3);

    // constrained random
    for (int t = 0; t < 20; t++) begin
      logic [6:0] a;
      logic rw;
      int n;
      a  = 7'($urandom);
      rw = 1'($urandom);
      n  = 1 + int'($urandom % 3);
      for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
      xfer(a, rw, n);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule